// File: doc/BRIEF.md
# Host Register and Frame Memory Access Port

This block is the slave side of a 32-bit host bus. A processor reaches two things through it: a small bank of control and status registers inside the block, and words of the external frame memory. Register accesses are single-cycle, qualified by an active-low select and an active-low write strobe, and written under four byte lanes. Reads return one cycle later on a shared data output, and an active-low drive flag tells board logic when to enable its bus drivers.

Frame memory accesses use their own active-low read and write request pins. The block latches the address, shows a busy flag, and runs a simple request/grant exchange toward a memory arbiter. Read data is held with a valid flag until the host strobes it away. Write data goes through a valid/ready handshake and is posted to the arbiter. An address window marks the picture storage area. Host memory accesses inside that window are refused unless a diagnostic bypass bit is set. A refusal never reaches the arbiter, returns zero on a read, and raises a status flag. Status flags, including the refusal flag and a set of external event inputs, drive a maskable active-low interrupt.

Top module: `host_access_port`

## Requirements
- R1: A register write happens at a rising edge where `hst_cs_n` and `hst_we_n` are both low, and only the byte lanes with `hst_be` bits set (bit i covers data bits 8i+7..8i) change. The register map uses word index `hst_addr[2:0]` with `hst_addr[21:3]` zero: 0 control (bit 0 = bypass), 1 status, 2 interrupt enable, 3 window low bound, 4 window high bound, 5 scratch (32 bits).
- R2: A register read starts at an edge where `hst_cs_n` is low and `hst_we_n` is high. The register value is on `hst_rdata` with `hst_rdrive_n` low during the next cycle. Unmapped indices, and addresses with any of bits 21..3 set, read as zero.
- R3: `mem_busy` goes high in the cycle after a memory request is accepted and stays high until the transaction completes. Requests that arrive while busy are ignored. A read request wins over a write request made in the same cycle.
- R4: A memory read issues one arbiter request and returns the arbiter data on `hst_rdata`. `mem_rvalid` stays high until an edge with `mem_rstrb` high, and after that edge both `mem_rvalid` and `mem_busy` are low.
- R5: During a memory write `mem_wready` is high until an edge with `mem_wvalid` high. The data and `hst_be` are captured at that edge and passed to the arbiter. `mem_busy` stays high until the arbiter grants.
- R6: A memory access whose address lies within the inclusive window [low bound, high bound] is refused while bypass is clear. No arbiter request is made, a refused read returns zero with `mem_rvalid`, and status bit N_SRC (4 by default) is set. After reset the low bound is 0x3FFFFF and the high bound is 0, so the window is empty.
- R7: With control bit 0 (bypass) set, window addresses are accessed normally.
- R8: Status bits [N_SRC-1:0] are set in any cycle where the matching `irq_src` bit is high. Writing 1 to a status bit clears it. A set in the same cycle takes priority over the clear.
- R9: `hst_irq_n` is low exactly when some status bit and its enable bit are both set. It is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 22 | Register index or memory word address |
| hst_wdata | input | 32 | Host write data |
| hst_be | input | 4 | Byte lane enables for writes |
| hst_cs_n | input | 1 | Register select, active low |
| hst_we_n | input | 1 | Register write strobe, active low (high = read) |
| hst_rdata | output | 32 | Register or memory read data |
| hst_rdrive_n | output | 1 | Low while read data is driven |
| mem_rd_req_n | input | 1 | Memory read request, active low |
| mem_wr_req_n | input | 1 | Memory write request, active low |
| mem_busy | output | 1 | Memory transaction in progress |
| mem_rvalid | output | 1 | Memory read data valid |
| mem_rstrb | input | 1 | Host takes read data at this edge |
| mem_wvalid | input | 1 | Host write data valid |
| mem_wready | output | 1 | Block ready for write data |
| hst_irq_n | output | 1 | Interrupt, active low |
| irq_src | input | N_SRC | Event inputs that set status bits |
| arb_req | output | 1 | Request to memory arbiter |
| arb_we | output | 1 | Request is a write |
| arb_addr | output | 22 | Arbiter word address |
| arb_wdata | output | 32 | Arbiter write data |
| arb_be | output | 4 | Arbiter byte enables |
| arb_gnt | input | 1 | Arbiter accepts request this edge |
| arb_rvalid | input | 1 | Arbiter read data valid |
| arb_rdata | input | 32 | Arbiter read data |

## Verification
A stuck transaction state shows first on `mem_busy`: a sequencer that never returns to idle leaves busy high. The bench then times out waiting for `mem_rvalid` or for busy to clear. A guard decision that is inverted or off by one at a window edge shows up within a handful of cycles, either as a changed arbiter handshake count or as nonzero data from a refused read. Status or enable bits held wrongly show on `hst_irq_n` one cycle after the causing edge. A byte-lane mix-up shows on the next register or memory readback.

// File: rtl/hap_pkg.sv
package hap_pkg;
    localparam int HAP_AW    = 22;
    localparam int HAP_DW    = 32;
    localparam int HAP_BEW   = HAP_DW / 8;
    localparam int HAP_NSRC  = 4;
    localparam int HAP_IXW   = 3;

    localparam logic [HAP_IXW-1:0] IX_CTRL  = 3'd0;
    localparam logic [HAP_IXW-1:0] IX_STAT  = 3'd1;
    localparam logic [HAP_IXW-1:0] IX_ENA   = 3'd2;
    localparam logic [HAP_IXW-1:0] IX_WLO   = 3'd3;
    localparam logic [HAP_IXW-1:0] IX_WHI   = 3'd4;
    localparam logic [HAP_IXW-1:0] IX_SCR   = 3'd5;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_RD_ARB,
        MS_RD_WAIT,
        MS_RD_HOLD,
        MS_WR_DATA,
        MS_WR_ARB
    } mstate_t;

    typedef struct packed {
        logic              we;
        logic              blocked;
        logic [HAP_AW-1:0] addr;
        logic [HAP_DW-1:0] data;
        logic [HAP_BEW-1:0] be;
    } mreq_t;

    function automatic logic [HAP_DW-1:0] lane_mask(input logic [HAP_BEW-1:0] be);
        logic [HAP_DW-1:0] m;
        for (int i = 0; i < HAP_BEW; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [HAP_DW-1:0] lane_merge(
        input logic [HAP_DW-1:0]  old_v,
        input logic [HAP_DW-1:0]  new_v,
        input logic [HAP_BEW-1:0] be
    );
        logic [HAP_DW-1:0] m;
        m = lane_mask(be);
        return (old_v & ~m) | (new_v & m);
    endfunction
endpackage

// File: rtl/hap_guard.sv
module hap_guard #(
    parameter int AW = hap_pkg::HAP_AW
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    input  logic          bypass,
    output logic          hit
);
    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (addr >= win_lo);
        below_hi = (addr <= win_hi);
        hit      = !bypass && above_lo && below_hi;
    end
endmodule

// File: rtl/hap_regfile.sv
module hap_regfile
    import hap_pkg::*;
#(
    parameter int NSRC = HAP_NSRC,
    parameter int AW   = HAP_AW,
    parameter int DW   = HAP_DW,
    parameter int BEW  = HAP_BEW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            we_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [BEW-1:0]  be,
    input  logic [NSRC-1:0] src,
    input  logic            viol,
    output logic [DW-1:0]   rdata_q,
    output logic            rd_q,
    output logic            bypass,
    output logic [AW-1:0]   win_lo,
    output logic [AW-1:0]   win_hi,
    output logic            irq_n
);
    localparam int STW = NSRC + 1;

    logic [STW-1:0] status;
    logic [STW-1:0] enable;
    logic [DW-1:0]  scratch;
    logic           sel_ok;
    logic [HAP_IXW-1:0] idx;
    logic           wr_en;
    logic           rd_en;
    logic [DW-1:0]  wmask;
    logic [STW-1:0] st_clr;
    logic [STW-1:0] st_set;
    logic [DW-1:0]  rd_val;
    logic [DW-1:0]  lo_ext;
    logic [DW-1:0]  hi_ext;
    logic [DW-1:0]  lo_new;
    logic [DW-1:0]  hi_new;

    always_comb begin
        sel_ok = (addr[AW-1:HAP_IXW] == '0);
        idx    = addr[HAP_IXW-1:0];
        wr_en  = !cs_n && !we_n && sel_ok;
        rd_en  = !cs_n && we_n;
        wmask  = lane_mask(be);
        st_clr = (wr_en && idx == IX_STAT) ? (wdata[STW-1:0] & wmask[STW-1:0]) : '0;
        st_set = {viol, src};
        lo_ext = {{(DW-AW){1'b0}}, win_lo};
        hi_ext = {{(DW-AW){1'b0}}, win_hi};
        lo_new = lane_merge(lo_ext, wdata, be);
        hi_new = lane_merge(hi_ext, wdata, be);
    end

    always_comb begin
        rd_val = '0;
        if (sel_ok) begin
            case (idx)
                IX_CTRL: rd_val = {{(DW-1){1'b0}}, bypass};
                IX_STAT: rd_val = {{(DW-STW){1'b0}}, status};
                IX_ENA:  rd_val = {{(DW-STW){1'b0}}, enable};
                IX_WLO:  rd_val = lo_ext;
                IX_WHI:  rd_val = hi_ext;
                IX_SCR:  rd_val = scratch;
                default: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass  <= 1'b0;
            enable  <= '0;
            win_lo  <= '1;
            win_hi  <= '0;
            scratch <= '0;
            status  <= '0;
            rd_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            status <= (status & ~st_clr) | st_set;
            rd_q   <= rd_en;
            if (rd_en) begin
                rdata_q <= rd_val;
            end
            if (wr_en) begin
                case (idx)
                    IX_CTRL: if (be[0]) bypass <= wdata[0];
                    IX_ENA:  enable  <= (enable & ~wmask[STW-1:0]) | (wdata[STW-1:0] & wmask[STW-1:0]);
                    IX_WLO:  win_lo  <= lo_new[AW-1:0];
                    IX_WHI:  win_hi  <= hi_new[AW-1:0];
                    IX_SCR:  scratch <= lane_merge(scratch, wdata, be);
                    default: ;
                endcase
            end
        end
    end

    assign irq_n = ~|(status & enable);
endmodule

// File: rtl/hap_memctl.sv
module hap_memctl
    import hap_pkg::*;
#(
    parameter int AW  = HAP_AW,
    parameter int DW  = HAP_DW,
    parameter int BEW = HAP_BEW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_req_n,
    input  logic           wr_req_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [BEW-1:0] be,
    input  logic           wvalid,
    input  logic           rstrb,
    input  logic [AW-1:0]  win_lo,
    input  logic [AW-1:0]  win_hi,
    input  logic           bypass,
    input  logic           arb_gnt,
    input  logic           arb_rvalid,
    input  logic [DW-1:0]  arb_rdata,
    output logic           busy,
    output logic           wready,
    output logic           rvalid,
    output logic [DW-1:0]  rdata,
    output logic           arb_req,
    output logic           arb_we,
    output logic [AW-1:0]  arb_addr,
    output logic [DW-1:0]  arb_wdata,
    output logic [BEW-1:0] arb_be,
    output logic           viol
);
    mstate_t state;
    mreq_t   req;
    logic    hit;

    hap_guard #(.AW(AW)) u_guard (
        .addr   (addr),
        .win_lo (win_lo),
        .win_hi (win_hi),
        .bypass (bypass),
        .hit    (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_IDLE;
            req   <= '0;
            rdata <= '0;
            viol  <= 1'b0;
        end else begin
            viol <= 1'b0;
            case (state)
                MS_IDLE: begin
                    if (!rd_req_n) begin
                        req.addr    <= addr;
                        req.we      <= 1'b0;
                        req.blocked <= hit;
                        if (hit) begin
                            rdata <= '0;
                            viol  <= 1'b1;
                            state <= MS_RD_HOLD;
                        end else begin
                            state <= MS_RD_ARB;
                        end
                    end else if (!wr_req_n) begin
                        req.addr    <= addr;
                        req.we      <= 1'b1;
                        req.blocked <= hit;
                        state       <= MS_WR_DATA;
                    end
                end
                MS_RD_ARB:  if (arb_gnt) state <= MS_RD_WAIT;
                MS_RD_WAIT: begin
                    if (arb_rvalid) begin
                        rdata <= arb_rdata;
                        state <= MS_RD_HOLD;
                    end
                end
                MS_RD_HOLD: if (rstrb) state <= MS_IDLE;
                MS_WR_DATA: begin
                    if (wvalid) begin
                        req.data <= wdata;
                        req.be   <= be;
                        if (req.blocked) begin
                            viol  <= 1'b1;
                            state <= MS_IDLE;
                        end else begin
                            state <= MS_WR_ARB;
                        end
                    end
                end
                MS_WR_ARB:  if (arb_gnt) state <= MS_IDLE;
                default:    state <= MS_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != MS_IDLE);
        wready    = (state == MS_WR_DATA);
        rvalid    = (state == MS_RD_HOLD);
        arb_req   = (state == MS_RD_ARB) || (state == MS_WR_ARB);
        arb_we    = req.we;
        arb_addr  = req.addr;
        arb_wdata = req.data;
        arb_be    = req.be;
    end
endmodule

// File: rtl/host_access_port.sv
module host_access_port
    import hap_pkg::*;
#(
    parameter int N_SRC = HAP_NSRC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HAP_AW-1:0]   hst_addr,
    input  logic [HAP_DW-1:0]   hst_wdata,
    input  logic [HAP_BEW-1:0]  hst_be,
    input  logic                hst_cs_n,
    input  logic                hst_we_n,
    output logic [HAP_DW-1:0]   hst_rdata,
    output logic                hst_rdrive_n,
    input  logic                mem_rd_req_n,
    input  logic                mem_wr_req_n,
    output logic                mem_busy,
    output logic                mem_rvalid,
    input  logic                mem_rstrb,
    input  logic                mem_wvalid,
    output logic                mem_wready,
    output logic                hst_irq_n,
    input  logic [N_SRC-1:0]    irq_src,
    output logic                arb_req,
    output logic                arb_we,
    output logic [HAP_AW-1:0]   arb_addr,
    output logic [HAP_DW-1:0]   arb_wdata,
    output logic [HAP_BEW-1:0]  arb_be,
    input  logic                arb_gnt,
    input  logic                arb_rvalid,
    input  logic [HAP_DW-1:0]   arb_rdata
);
    logic [HAP_DW-1:0] reg_rdata;
    logic              reg_rd;
    logic              bypass;
    logic [HAP_AW-1:0] win_lo;
    logic [HAP_AW-1:0] win_hi;
    logic              viol;
    logic [HAP_DW-1:0] mem_rdata;

    hap_regfile #(
        .NSRC (N_SRC),
        .AW   (HAP_AW),
        .DW   (HAP_DW),
        .BEW  (HAP_BEW)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (hst_cs_n),
        .we_n    (hst_we_n),
        .addr    (hst_addr),
        .wdata   (hst_wdata),
        .be      (hst_be),
        .src     (irq_src),
        .viol    (viol),
        .rdata_q (reg_rdata),
        .rd_q    (reg_rd),
        .bypass  (bypass),
        .win_lo  (win_lo),
        .win_hi  (win_hi),
        .irq_n   (hst_irq_n)
    );

    hap_memctl #(
        .AW  (HAP_AW),
        .DW  (HAP_DW),
        .BEW (HAP_BEW)
    ) u_mem (
        .clk        (clk),
        .rst        (rst),
        .rd_req_n   (mem_rd_req_n),
        .wr_req_n   (mem_wr_req_n),
        .addr       (hst_addr),
        .wdata      (hst_wdata),
        .be         (hst_be),
        .wvalid     (mem_wvalid),
        .rstrb      (mem_rstrb),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .bypass     (bypass),
        .arb_gnt    (arb_gnt),
        .arb_rvalid (arb_rvalid),
        .arb_rdata  (arb_rdata),
        .busy       (mem_busy),
        .wready     (mem_wready),
        .rvalid     (mem_rvalid),
        .rdata      (mem_rdata),
        .arb_req    (arb_req),
        .arb_we     (arb_we),
        .arb_addr   (arb_addr),
        .arb_wdata  (arb_wdata),
        .arb_be     (arb_be),
        .viol       (viol)
    );

    always_comb begin
        if (reg_rd) begin
            hst_rdata = reg_rdata;
        end else if (mem_rvalid) begin
            hst_rdata = mem_rdata;
        end else begin
            hst_rdata = '0;
        end
        hst_rdrive_n = !(reg_rd || mem_rvalid);
    end
endmodule

// File: rtl/hap_checker.sv
module hap_checker (
    input logic                      clk,
    input logic                      rst,
    input logic                      hst_cs_n,
    input logic                      hst_we_n,
    input logic                      hst_rdrive_n,
    input logic                      mem_busy,
    input logic                      mem_rvalid,
    input logic                      mem_rstrb,
    input logic                      mem_wready,
    input logic                      arb_req,
    input logic                      arb_we,
    input logic [hap_pkg::HAP_AW-1:0] arb_addr,
    input logic                      arb_gnt
);
    a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
        (!hst_cs_n && hst_we_n) |=> !hst_rdrive_n);

    a_r3_arb_inside_busy: assert property (@(posedge clk) disable iff (rst)
        arb_req |-> mem_busy);

    a_r4_rvalid_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rvalid && !mem_rstrb) |=> mem_rvalid);

    a_r5_wready_no_arb: assert property (@(posedge clk) disable iff (rst)
        mem_wready |-> (mem_busy && !arb_req));

    a_r5_arb_req_stable: assert property (@(posedge clk) disable iff (rst)
        (arb_req && !arb_gnt) |=> (arb_req && $stable(arb_addr) && $stable(arb_we)));
endmodule

bind host_access_port hap_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .hst_cs_n     (hst_cs_n),
    .hst_we_n     (hst_we_n),
    .hst_rdrive_n (hst_rdrive_n),
    .mem_busy     (mem_busy),
    .mem_rvalid   (mem_rvalid),
    .mem_rstrb    (mem_rstrb),
    .mem_wready   (mem_wready),
    .arb_req      (arb_req),
    .arb_we       (arb_we),
    .arb_addr     (arb_addr),
    .arb_gnt      (arb_gnt)
);

// File: tb/host_access_port_tb.sv
module host_access_port_tb;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [3:0]  hst_be = '0;
    logic        hst_cs_n = 1'b1;
    logic        hst_we_n = 1'b1;
    logic [31:0] hst_rdata;
    logic        hst_rdrive_n;
    logic        mem_rd_req_n = 1'b1;
    logic        mem_wr_req_n = 1'b1;
    logic        mem_busy;
    logic        mem_rvalid;
    logic        mem_rstrb = 1'b0;
    logic        mem_wvalid = 1'b0;
    logic        mem_wready;
    logic        hst_irq_n;
    logic [NS-1:0] irq_src = '0;
    logic        arb_req;
    logic        arb_we;
    logic [21:0] arb_addr;
    logic [31:0] arb_wdata;
    logic [3:0]  arb_be;
    logic        arb_gnt = 1'b0;
    logic        arb_rvalid = 1'b0;
    logic [31:0] arb_rdata = '0;

    int total = 0;
    int bad = 0;
    int arb_count = 0;
    logic [31:0] tmem [0:255];

    always #4 clk = ~clk;

    host_access_port #(.N_SRC(NS)) u_dut (
        .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_be(hst_be), .hst_cs_n(hst_cs_n), .hst_we_n(hst_we_n),
        .hst_rdata(hst_rdata), .hst_rdrive_n(hst_rdrive_n),
        .mem_rd_req_n(mem_rd_req_n), .mem_wr_req_n(mem_wr_req_n),
        .mem_busy(mem_busy), .mem_rvalid(mem_rvalid), .mem_rstrb(mem_rstrb),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .hst_irq_n(hst_irq_n),
        .irq_src(irq_src), .arb_req(arb_req), .arb_we(arb_we),
        .arb_addr(arb_addr), .arb_wdata(arb_wdata), .arb_be(arb_be),
        .arb_gnt(arb_gnt), .arb_rvalid(arb_rvalid), .arb_rdata(arb_rdata)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return 32'h5EED0000 | {24'h0, a} | ({24'h0, a} << 12);
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) tmem[i] = pat(i[7:0]);
    end

    // Arbiter model: grant one cycle after a request, data one cycle after grant.
    always @(posedge clk) begin
        arb_gnt    <= 1'b0;
        arb_rvalid <= 1'b0;
        if (arb_req && !arb_gnt) arb_gnt <= 1'b1;
        if (arb_req && arb_gnt) begin
            arb_count <= arb_count + 1;
            if (arb_we) begin
                for (int b = 0; b < 4; b++)
                    if (arb_be[b]) tmem[arb_addr[7:0]][b*8 +: 8] <= arb_wdata[b*8 +: 8];
            end else begin
                arb_rvalid <= 1'b1;
                arb_rdata  <= tmem[arb_addr[7:0]];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [21:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        hst_cs_n = 1'b0; hst_we_n = 1'b0; hst_addr = a; hst_wdata = d; hst_be = be;
        @(negedge clk);
        hst_cs_n = 1'b1; hst_we_n = 1'b1;
    endtask

    task automatic reg_rd(input logic [21:0] a, output logic [31:0] d, output logic drv);
        @(negedge clk);
        hst_cs_n = 1'b0; hst_we_n = 1'b1; hst_addr = a;
        @(negedge clk);
        d = hst_rdata; drv = hst_rdrive_n;
        hst_cs_n = 1'b1;
    endtask

    task automatic mem_rd(input logic [21:0] a, output logic [31:0] d, output logic busy1);
        int n;
        @(negedge clk);
        mem_rd_req_n = 1'b0; hst_addr = a;
        @(negedge clk);
        mem_rd_req_n = 1'b1; busy1 = mem_busy;
        n = 0;
        while (!mem_rvalid && n < 60) begin @(negedge clk); n++; end
        d = hst_rdata;
        mem_rstrb = 1'b1;
        @(negedge clk);
        mem_rstrb = 1'b0;
    endtask

    task automatic mem_wr(input logic [21:0] a, input logic [31:0] d, input logic [3:0] be);
        int n;
        @(negedge clk);
        mem_wr_req_n = 1'b0; hst_addr = a;
        @(negedge clk);
        mem_wr_req_n = 1'b1;
        n = 0;
        while (!mem_wready && n < 60) begin @(negedge clk); n++; end
        hst_wdata = d; hst_be = be; mem_wvalid = 1'b1;
        @(negedge clk);
        mem_wvalid = 1'b0;
        n = 0;
        while (mem_busy && n < 60) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset;
        logic [31:0] d; logic drv;
        chk("R9 irq high after reset", {31'b0, hst_irq_n}, 32'h1);
        chk("R3 idle after reset", {31'b0, mem_busy}, 32'h0);
        chk("R2 no drive after reset", {31'b0, hst_rdrive_n}, 32'h1);
        reg_rd(22'd3, d, drv);
        chk("R6 low bound reset", d, 32'h003FFFFF);
        reg_rd(22'd1, d, drv);
        chk("R8 status reset", d, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d; logic drv;
        reg_wr(22'd5, 32'hFFFFFFFF, 4'b1111);
        reg_wr(22'd5, 32'h12345678, 4'b0101);
        reg_rd(22'd5, d, drv);
        chk("R1 scratch lanes", d, 32'hFF34FF78);
        chk("R2 drive low with data", {31'b0, drv}, 32'h0);
        @(negedge clk);
        chk("R2 drive released", {31'b0, hst_rdrive_n}, 32'h1);
        reg_wr(22'd0, 32'h1, 4'b0000);
        reg_rd(22'd0, d, drv);
        chk("R1 no lane no write", d, 32'h0);
        reg_rd(22'd7, d, drv);
        chk("R2 unmapped index", d, 32'h0);
        reg_rd(22'h000105, d, drv);
        chk("R2 high address bits", d, 32'h0);
    endtask

    task automatic t_mem;
        logic [31:0] d; logic b1;
        mem_rd(22'd5, d, b1);
        chk("R3 busy after read request", {31'b0, b1}, 32'h1);
        chk("R4 read data", d, pat(8'd5));
        chk("R4 rvalid cleared", {31'b0, mem_rvalid}, 32'h0);
        chk("R4 busy cleared", {31'b0, mem_busy}, 32'h0);
        // hold without strobe
        @(negedge clk); mem_rd_req_n = 1'b0; hst_addr = 22'd9;
        @(negedge clk); mem_rd_req_n = 1'b1;
        for (int k = 0; k < 8; k++) @(negedge clk);
        mem_wr_req_n = 1'b0; hst_addr = 22'd9;
        @(negedge clk); mem_wr_req_n = 1'b1;
        chk("R4 rvalid held", {31'b0, mem_rvalid}, 32'h1);
        chk("R4 held data", hst_rdata, pat(8'd9));
        mem_rstrb = 1'b1; @(negedge clk); mem_rstrb = 1'b0;
        chk("R3 request while busy ignored", {31'b0, mem_busy}, 32'h0);
        mem_wr(22'd6, 32'hAABBCCDD, 4'b0011);
        mem_rd(22'd6, d, b1);
        chk("R5 write lanes", d, (pat(8'd6) & 32'hFFFF0000) | 32'h0000CCDD);
    endtask

    task automatic t_guard;
        logic [31:0] d; logic drv; logic b1; int c0;
        reg_wr(22'd3, 32'h10, 4'b1111);
        reg_wr(22'd4, 32'h1F, 4'b1111);
        mem_rd(22'h0F, d, b1);
        chk("R6 below window allowed", d, pat(8'h0F));
        c0 = arb_count;
        mem_rd(22'h10, d, b1);
        chk("R6 refused read zero", d, 32'h0);
        chk("R6 no arbiter request", arb_count, c0);
        reg_rd(22'd1, d, drv);
        chk("R6 refusal flag", d & 32'h10, 32'h10);
        mem_wr(22'h1F, 32'hDEADBEEF, 4'b1111);
        chk("R6 refused write no request", arb_count, c0);
        reg_wr(22'd0, 32'h1, 4'b0001);
        mem_rd(22'h1F, d, b1);
        chk("R7 bypass read, write was blocked", d, pat(8'h1F));
        mem_wr(22'h1F, 32'h0BADF00D, 4'b1111);
        mem_rd(22'h1F, d, b1);
        chk("R7 bypass write", d, 32'h0BADF00D);
        reg_wr(22'd0, 32'h0, 4'b0001);
    endtask

    task automatic t_irq;
        logic [31:0] d; logic drv;
        reg_wr(22'd1, 32'h1F, 4'b0001);
        reg_wr(22'd2, 32'h02, 4'b0001);
        chk("R9 irq idle", {31'b0, hst_irq_n}, 32'h1);
        @(negedge clk); irq_src = 4'b0001;
        @(negedge clk); irq_src = 4'b0000;
        chk("R9 masked source", {31'b0, hst_irq_n}, 32'h1);
        @(negedge clk); irq_src = 4'b0010;
        @(negedge clk); irq_src = 4'b0000;
        chk("R9 enabled source", {31'b0, hst_irq_n}, 32'h0);
        reg_rd(22'd1, d, drv);
        chk("R8 status bits", d, 32'h3);
        reg_wr(22'd1, 32'h2, 4'b0001);
        chk("R8 R9 clear releases irq", {31'b0, hst_irq_n}, 32'h1);
        @(negedge clk); irq_src = 4'b0100;
        hst_cs_n = 1'b0; hst_we_n = 1'b0; hst_addr = 22'd1; hst_wdata = 32'h4; hst_be = 4'b0001;
        @(negedge clk); irq_src = 4'b0000; hst_cs_n = 1'b1; hst_we_n = 1'b1;
        reg_rd(22'd1, d, drv);
        chk("R8 set wins over clear", d, 32'h5);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mem();
        t_guard();
        t_irq();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule